// File: doc/BRIEF.md
# Periodic Interrupt Timer Controller

This block raises a periodic interrupt from a slow tick. Two tick sources arrive as single-cycle enables in the system clock domain: one from an external pin and one from an oscillator. A field in the control register chooses between them. A 15-bit prescale counter advances on each selected tick. When it completes the chosen interval, which is a power of two from 512 to 32768 ticks, it sets a pending flag. Software clears the flag by writing one to it. An active-high mask stops the flag from reaching the registered interrupt output.

All control and status live in one 8-bit register on a simple CPU register bus. The bus has an address, a write strobe, write data and combinational read data. Writing a different period code or source code restarts the current interval from zero. Period code zero stops the timer.

Top module: `pit_ctrl`

## Requirements
- R1: After reset the register reads 0x20 (source field 10, every other bit 0) and the interrupt output is 0.
- R2: Register bit positions are: bit 7 pending flag, bit 6 mask, bits 5:4 source select, bit 3 unused, bits 2:0 period code. Bit 3 always reads 0 and ignores writes. A read at any address other than the register address returns 0.
- R3: Source code 01 counts only pin ticks and code 10 counts only oscillator ticks. Codes 00 and 11 count no ticks.
- R4: For period code n in 1..7, the pending flag sets on the 2^(n+8)-th selected tick after the interval starts. The flag is visible on the edge that takes that tick, and the counter wraps to zero on the same edge.
- R5: With period code 000 the counter holds and the pending flag is never set by the timer.
- R6: A register write with bit 7 set clears the pending flag. A write with bit 7 clear leaves the flag unchanged.
- R7: If a write-one-to-clear and an interval completion fall on the same edge, the pending flag stays set.
- R8: The interrupt output is a register. It equals pending AND NOT mask, as those two bits stood one cycle earlier. While the mask is 1, the output stays 0.
- R9: A write whose period code or source code differs from the current value restarts the counter at zero. A write that leaves both codes unchanged does not disturb the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| pin_tick_i | input | 1 | Single-cycle tick from the external pin source |
| osc_tick_i | input | 1 | Single-cycle tick from the oscillator source |
| reg_addr_i | input | 4 | Register bus address |
| reg_wr_i | input | 1 | Register bus write strobe |
| reg_wdata_i | input | 8 | Register bus write data |
| reg_rdata_o | output | 8 | Register bus read data (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions check several rules on every cycle:
- reserved source codes yield no ticks;
- the counter stays frozen and raises no completion while the period code is zero;
- the counter never exceeds the interval limit, and a restart leaves it at zero;
- a completion always leaves the flag set;
- the mask and the flag drive the interrupt one cycle later.

Only the bench scenarios can show the exact length of each interval in ticks. They also show that the source select ignores the unselected tick, that an unchanged rewrite keeps the count, and that the read-back layout is correct. A cycle-accurate reference model, run across directed cases and random writes and ticks, covers these.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int unsigned REG_W = 8;

  typedef enum logic [1:0] {
    SRC_OFF_LO = 2'b00,
    SRC_PIN    = 2'b01,
    SRC_OSC    = 2'b10,
    SRC_OFF_HI = 2'b11
  } tick_src_e;

  // Bit positions are fixed by software: 7 flag, 6 mask, 5:4 source, 3 unused, 2:0 period
  typedef struct packed {
    logic       pend;
    logic       mask;
    tick_src_e  src;
    logic       unused;
    logic [2:0] period;
  } pit_ctrl_t;

  localparam pit_ctrl_t CTRL_RESET = '{
    pend:   1'b0,
    mask:   1'b0,
    src:    SRC_OSC,
    unused: 1'b0,
    period: 3'd0
  };

endpackage

// File: rtl/pit_tick_sel.sv
module pit_tick_sel
  import pit_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tick_src_e src_i,
  input  logic      pin_tick_i,
  input  logic      osc_tick_i,
  output logic      tick_o
);

  always_comb begin
    unique case (src_i)
      SRC_PIN: tick_o = pin_tick_i;
      SRC_OSC: tick_o = osc_tick_i;
      default: tick_o = 1'b0;
    endcase
  end

  AST_RESERVED_SRC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_i == SRC_OFF_LO) || (src_i == SRC_OFF_HI)) |-> !tick_o); // R3

endmodule

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned CNT_W      = 15,
  parameter int unsigned PER_W      = 3,
  parameter int unsigned BASE_SHIFT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [PER_W-1:0] period_i,
  output logic             term_o
);

  localparam int unsigned SPAN_W = CNT_W + 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  last_cnt;
  logic [SPAN_W-1:0] span;
  logic              run;
  logic              cnt_en;
  logic              term;

  // Interval length is 2^(code + BASE_SHIFT - 1); code 0 halts the timer
  always_comb begin
    span     = SPAN_W'(1) << (int'(period_i) + int'(BASE_SHIFT) - 1);
    last_cnt = CNT_W'(span - SPAN_W'(1));
    run      = (period_i != '0);
  end

  always_comb begin
    cnt_nxt = cnt_q;
    term    = 1'b0;
    if (restart_i) begin
      cnt_nxt = '0;
    end else if (run && tick_i) begin
      if (cnt_q == last_cnt) begin
        cnt_nxt = '0;
        term    = 1'b1;
      end else begin
        cnt_nxt = cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_en = restart_i | (run & tick_i);
  assign term_o = term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((period_i == '0) && !restart_i) |=> $stable(cnt_q)); // R5
  AST_NO_TERM_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (period_i == '0) |-> !term_o); // R5
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (period_i != '0) |-> (cnt_q <= last_cnt)); // R4
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_hit_i,
  input  pit_ctrl_t wdata_i,
  input  logic      term_i,
  output pit_ctrl_t ctrl_o,
  output logic      restart_o,
  output logic      irq_o
);

  pit_ctrl_t ctrl_q;
  pit_ctrl_t ctrl_nxt;
  logic      irq_q;
  logic      irq_nxt;
  logic      clr_req;

  always_comb begin
    ctrl_nxt  = ctrl_q;
    clr_req   = wr_hit_i & wdata_i.pend;
    restart_o = 1'b0;
    if (wr_hit_i) begin
      ctrl_nxt.mask   = wdata_i.mask;
      ctrl_nxt.src    = wdata_i.src;
      ctrl_nxt.period = wdata_i.period;
      restart_o       = (wdata_i.src != ctrl_q.src) || (wdata_i.period != ctrl_q.period);
    end
    ctrl_nxt.unused = 1'b0;
    // A fresh completion wins over a simultaneous clear
    ctrl_nxt.pend   = term_i | (ctrl_q.pend & ~clr_req);
    irq_nxt         = ctrl_q.pend & ~ctrl_q.mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nxt;
      irq_q  <= irq_nxt;
    end
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = irq_q;

  AST_TERM_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    term_i |=> ctrl_q.pend); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit_i && wdata_i.pend && !term_i) |=> !ctrl_q.pend); // R6
  AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.mask |=> !irq_q); // R8
  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.pend && !ctrl_q.mask) |=> irq_q); // R8

endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned REG_ADDR   = 0,
  parameter int unsigned CNT_W      = 15,
  parameter int unsigned BASE_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_tick_i,
  input  logic              osc_tick_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);

  localparam int unsigned PER_W = 3;
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       addr_hit;
  logic       wr_hit;
  logic       tick;
  logic       term;
  logic       restart;
  pit_ctrl_t  ctrl;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  assign addr_hit = (reg_addr_i == MY_ADDR);
  assign wr_hit   = reg_wr_i & addr_hit;

  pit_tick_sel u_tick_sel (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .src_i      (ctrl.src),
    .pin_tick_i (pin_tick_i),
    .osc_tick_i (osc_tick_i),
    .tick_o     (tick)
  );

  pit_prescaler #(
    .CNT_W      (CNT_W),
    .PER_W      (PER_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick_i    (tick),
    .restart_i (restart),
    .period_i  (ctrl.period),
    .term_o    (term)
  );

  pit_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_hit_i  (wr_hit),
    .wdata_i   (pit_ctrl_t'(reg_wdata_i)),
    .term_i    (term),
    .ctrl_o    (ctrl),
    .restart_o (restart),
    .irq_o     (irq_o)
  );

  assign reg_rdata_o = addr_hit ? REG_W'(ctrl) : '0;

  AST_UNUSED_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    !reg_rdata_o[3]); // R2

endmodule

// File: tb/test_pit_ctrl.sv
`timescale 1ns/1ps
module test_pit_ctrl;

  logic       clk;
  logic       rst_n;
  logic       pin_tick;
  logic       osc_tick;
  logic [3:0] addr;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq;

  int checks;
  int fails;
  bit done;

  // reference state
  int m_cnt;
  bit m_pend, m_mask, m_irq;
  int m_src, m_per;

  pit_ctrl i_pit_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_tick_i  (pin_tick),
    .osc_tick_i  (osc_tick),
    .reg_addr_i  (addr),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_rd(input logic [3:0] a);
    if (a != 4'd0) return 0;
    return (int'(m_pend) << 7) | (int'(m_mask) << 6) | (m_src << 4) | m_per;
  endfunction

  function automatic int last_of(input int per);
    return (1 << (per + 8)) - 1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: compare, drive, take one rising edge, update model
  task automatic step(input bit pt, input bit ot, input bit w, input logic [3:0] a, input logic [7:0] d);
    bit sel, hit, clr, term, clear_req;
    int ncnt;
    chk("R2 readback", int'(rdata), exp_rd(addr));
    chk("R8 irq", int'(irq), int'(m_irq));
    pin_tick = pt; osc_tick = ot; wr = w; addr = a; wdata = d;
    sel  = (m_src == 1 && pt) || (m_src == 2 && ot);
    hit  = w && (a == 4'd0);
    clr  = hit && ((int'(d[5:4]) != m_src) || (int'(d[2:0]) != m_per));
    term = 1'b0;
    ncnt = m_cnt;
    if (clr) ncnt = 0;
    else if (m_per != 0 && sel) begin
      if (m_cnt == last_of(m_per)) begin ncnt = 0; term = 1'b1; end
      else ncnt = m_cnt + 1;
    end
    clear_req = hit && d[7];
    @(posedge clk);
    m_irq  = m_pend && !m_mask;
    m_pend = term || (m_pend && !clear_req);
    m_cnt  = ncnt;
    if (hit) begin
      m_mask = d[6]; m_src = int'(d[5:4]); m_per = int'(d[2:0]);
    end
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic idle(input int n, input bit pt, input bit ot);
    for (int i = 0; i < n; i++) step(pt, ot, 1'b0, 4'd0, 8'h00);
  endtask

  task automatic wreg(input logic [7:0] d);
    step(1'b0, 1'b0, 1'b1, 4'd0, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; pin_tick = 0; osc_tick = 0; addr = 0; wr = 0; wdata = 0;
    m_cnt = 0; m_pend = 0; m_mask = 0; m_irq = 0; m_src = 2; m_per = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 reset value", int'(rdata), 32'h20);
    chk("R1 reset irq", int'(irq), 0);

    // R2: bit 3 ignored, foreign address reads 0
    wreg(8'h28);
    chk("R2 bit3 zero", int'(rdata), 32'h20);
    step(1'b0, 1'b0, 1'b0, 4'd5, 8'h00);
    chk("R2 foreign addr", int'(rdata), 0);
    idle(1, 0, 0);

    // R4: period code 1 = 512 oscillator ticks
    wreg(8'h21);
    idle(511, 0, 1);
    chk("R4 before 512", int'(rdata[7]), 0);
    idle(1, 0, 1);
    chk("R4 flag at 512", int'(rdata[7]), 1);
    chk("R8 irq lags flag", int'(irq), 0);
    idle(1, 0, 0);
    chk("R8 irq one cycle later", int'(irq), 1);

    // R6: write 0 keeps, write 1 clears
    wreg(8'h21);
    chk("R6 write0 keeps", int'(rdata[7]), 1);
    wreg(8'hA1);
    chk("R6 write1 clears", int'(rdata[7]), 0);
    idle(1, 0, 0);
    chk("R8 irq drops", int'(irq), 0);

    // R8: mask holds irq low, unmask releases it
    wreg(8'h61);
    idle(512, 0, 1);
    chk("R8 masked flag set", int'(rdata[7]), 1);
    idle(2, 0, 0);
    chk("R8 masked irq", int'(irq), 0);
    wreg(8'h21);
    idle(1, 0, 0);
    chk("R8 unmasked irq", int'(irq), 1);
    wreg(8'hA1);

    // R3: pin source ignores oscillator ticks
    wreg(8'h91);
    idle(600, 0, 1);
    chk("R3 pin ignores osc", int'(rdata[7]), 0);
    idle(512, 1, 0);
    chk("R3 pin counts", int'(rdata[7]), 1);
    wreg(8'h81);
    idle(600, 1, 1);
    chk("R3 code00 silent", int'(rdata[7]), 0);
    wreg(8'hB1);
    idle(600, 1, 1);
    chk("R3 code11 silent", int'(rdata[7]), 0);

    // R5: period 0 holds
    wreg(8'h20);
    idle(1500, 1, 1);
    chk("R5 disabled no flag", int'(rdata[7]), 0);

    // R9: changed code restarts, unchanged rewrite does not
    wreg(8'h22);
    idle(300, 0, 1);
    wreg(8'h21);
    idle(511, 0, 1);
    chk("R9 restart on change", int'(rdata[7]), 0);
    idle(1, 0, 1);
    chk("R9 restart interval", int'(rdata[7]), 1);
    wreg(8'hA1);
    idle(300, 0, 1);
    wreg(8'h21);
    idle(212, 0, 1);
    chk("R9 same code keeps count", int'(rdata[7]), 1);

    // R7: clear collides with completion
    wreg(8'hA1);
    idle(511, 0, 1);
    step(1'b0, 1'b1, 1'b1, 4'd0, 8'hA1);
    chk("R7 set beats clear", int'(rdata[7]), 1);
    wreg(8'hA1);

    // R4: longest interval
    wreg(8'hA7);
    idle(32767, 0, 1);
    chk("R4 before 32768", int'(rdata[7]), 0);
    idle(1, 0, 1);
    chk("R4 flag at 32768", int'(rdata[7]), 1);

    // random mix against the model
    wreg(8'hA1);
    for (int i = 0; i < 40000; i++) begin
      automatic int r = int'($urandom_range(0, 99));
      if (r < 2) begin
        automatic logic [7:0] d = 8'($urandom);
        if ($urandom_range(0, 3) != 0) d[2:0] = 3'($urandom_range(0, 2));
        if ($urandom_range(0, 3) != 0) d[5:4] = 2'($urandom_range(1, 2));
        step(1'($urandom), 1'($urandom), 1'b1, ($urandom_range(0, 7) == 0) ? 4'd3 : 4'd0, d);
      end else begin
        step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0), 1'b0,
             ($urandom_range(0, 15) == 0) ? 4'd9 : 4'd0, 8'h00);
      end
    end
    idle(2, 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule